// File: doc/BRIEF.md
# Block-Write Masked Write Datapath

This block sits between a decoded command stream and a 16-bit-wide video memory array. For each write command it produces a registered column-enable vector for one eight-column block, a per-bit write enable vector and the word to be written. It also holds a color register, a write-mask register, and a flag that records whether masking is persistent. A behavioural array inside the block takes those enables, so the results of any command sequence can be read back through a simple read port.

A normal write stores the bus word into one column. A block write fills any subset of the eight columns of a block with the color register in one cycle, and takes the column subset from the data bus. Masking picks, bit by bit, which I/O bits a write may change. The mask comes from the stored register once it has been loaded, or from a per-cycle mask input otherwise. Two byte strobes further restrict writes and register loads to the lower or upper byte.

Top module: `vram_wr_path`

## Requirements
- R1: Synchronous active-high reset clears the outputs `wr_valid`, `col_en` and `bit_en`, the color register, the mask register and the persistent flag.
- R2: A normal write (op 1) is issued one cycle later with `wr_valid`=1, `wr_blk`=col_addr[8:3], exactly the one column col_addr[2:0] enabled in `col_en`, and `wr_data` equal to `dq`.
- R3: A block write (op 2) is issued one cycle later with `wr_blk`=col_addr[8:3] (col_addr[2:0] ignored), `col_en`=dq[7:0] (a 1 enables that column) and `wr_data` equal to the color register.
- R4: With `masked`=0, writes and block writes enable every bit that the byte strobes allow, and the stored mask and persistent flag stay as they were.
- R5: With `masked`=1 and the persistent flag clear, the bit enables are `mask_in` (1 = bit writable) gated by the byte strobes.
- R6: A mask load (op 3) stores `dq` into the mask register and sets the persistent flag. Later masked writes then use the stored mask and ignore `mask_in`.
- R7: Refresh with clear (op 6) clears the persistent flag. Plain refresh (op 5) leaves it set.
- R8: `be_lo` gates bits 7:0 and `be_hi` gates bits 15:8 of write bit enables, of mask loads and of color loads. A load leaves a byte that is not strobed unchanged.
- R9: The array changes exactly the enabled bits of the enabled columns of the addressed block. `rd_data` returns column `rd_col` one cycle after it is presented.
- R10: No-op (0, 7), loads and refreshes leave `wr_valid`=0 and `col_en`=0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 3 | Command: 0 nop, 1 write, 2 block write, 3 load mask, 4 load color, 5 refresh, 6 refresh with clear, 7 nop |
| masked | input | 1 | Apply write-per-bit masking to this write |
| mask_in | input | 16 | Per-cycle bit mask used when not persistent |
| col_addr | input | 9 | Column address; bits 8:3 pick the block |
| dq | input | 16 | Data bus: write word, column mask, or register load value |
| be_lo | input | 1 | Lower byte strobe (bits 7:0) |
| be_hi | input | 1 | Upper byte strobe (bits 15:8) |
| rd_col | input | 9 | Column to read back |
| wr_valid | output | 1 | A write is issued to the array this cycle |
| wr_blk | output | 6 | Block index of the issued write |
| col_en | output | 8 | Column enables within the block |
| bit_en | output | 16 | Per-bit write enables |
| wr_data | output | 16 | Word written into the enabled columns |
| rd_data | output | 16 | Read-back word, one cycle after rd_col |

## Verification
Directed sequences separate the mask sources. A load followed by masked writes with a different `mask_in` shows whether the stored or the per-cycle mask was taken. Refresh and refresh-with-clear between those writes show which command ends the persistent mode, and an unmasked write placed in the middle shows whether it disturbs the stored mask. Block writes with sparse column patterns and nonzero low address bits show whether the column set comes from the bus or from the address. A long pseudo-random mix of all commands with random strobes is followed by a readback of every column, compared with an arithmetic model, to expose any stray bit or column written.

// File: rtl/vram_wr_pkg.sv
package vram_wr_pkg;
  localparam logic [2:0] OP_NOP      = 3'd0;
  localparam logic [2:0] OP_WRITE    = 3'd1;
  localparam logic [2:0] OP_BLKWR    = 3'd2;
  localparam logic [2:0] OP_LDMASK   = 3'd3;
  localparam logic [2:0] OP_LDCOLOR  = 3'd4;
  localparam logic [2:0] OP_RFSH     = 3'd5;
  localparam logic [2:0] OP_RFSH_CLR = 3'd6;
endpackage

// File: rtl/wr_mask_regs.sv
module wr_mask_regs
  import vram_wr_pkg::*;
#(
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       op_code,
  input  logic [DW-1:0]    dq,
  input  logic [LANES-1:0] lane_en,
  output logic [DW-1:0]    mask_q,
  output logic [DW-1:0]    color_q,
  output logic             persist_q
);
  localparam int LW = DW / LANES;

  always_ff @(posedge clk) begin
    if (rst) begin
      persist_q <= 1'b0;
    end else if (op_code == OP_LDMASK) begin
      persist_q <= 1'b1;
    end else if (op_code == OP_RFSH_CLR) begin
      persist_q <= 1'b0;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[l*LW +: LW]  <= '0;
        color_q[l*LW +: LW] <= '0;
      end else begin
        if (op_code == OP_LDMASK && lane_en[l])
          mask_q[l*LW +: LW] <= dq[l*LW +: LW];
        if (op_code == OP_LDCOLOR && lane_en[l])
          color_q[l*LW +: LW] <= dq[l*LW +: LW];
      end
    end
  end

  // R6
  ldmask_sets_persist_chk: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_LDMASK) |=> persist_q);
  // R7
  plain_refresh_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_RFSH && persist_q) |=> persist_q);
  // R7
  clear_refresh_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_RFSH_CLR) |=> !persist_q);
  // R8
  mask_lane_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_LDMASK && !lane_en[0]) |=> $stable(mask_q[LW-1:0]));
endmodule

// File: rtl/wr_enable_gen.sv
module wr_enable_gen
  import vram_wr_pkg::*;
#(
  parameter int DW       = 16,
  parameter int LANES    = 2,
  parameter int COL_AW   = 9,
  parameter int BLK_COLS = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [2:0]                 op_code,
  input  logic                       masked,
  input  logic [DW-1:0]              mask_in,
  input  logic [COL_AW-1:0]          col_addr,
  input  logic [DW-1:0]              dq,
  input  logic [LANES-1:0]           lane_en,
  input  logic [DW-1:0]              mask_q,
  input  logic [DW-1:0]              color_q,
  input  logic                       persist_q,
  output logic                       wr_valid,
  output logic [COL_AW-$clog2(BLK_COLS)-1:0] wr_blk,
  output logic [BLK_COLS-1:0]        col_en,
  output logic [DW-1:0]              bit_en,
  output logic [DW-1:0]              wr_data
);
  localparam int SEL_W = $clog2(BLK_COLS);
  localparam int LW    = DW / LANES;

  logic              is_wr, is_blk, blk_q;
  logic [DW-1:0]     lane_bits, sel_mask;
  logic [BLK_COLS-1:0] one_col;

  assign is_wr  = (op_code == OP_WRITE);
  assign is_blk = (op_code == OP_BLKWR);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_bits[l*LW +: LW] = {LW{lane_en[l]}};
  end

  always_comb begin
    one_col = '0;
    one_col[col_addr[SEL_W-1:0]] = 1'b1;
    if (!masked)        sel_mask = '1;
    else if (persist_q) sel_mask = mask_q;
    else                sel_mask = mask_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid <= 1'b0;
      blk_q    <= 1'b0;
      wr_blk   <= '0;
      col_en   <= '0;
      bit_en   <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= is_wr | is_blk;
      blk_q    <= is_blk;
      if (is_wr || is_blk) begin
        wr_blk  <= col_addr[COL_AW-1:SEL_W];
        col_en  <= is_blk ? dq[BLK_COLS-1:0] : one_col;
        bit_en  <= sel_mask & lane_bits;
        wr_data <= is_blk ? color_q : dq;
      end else begin
        col_en <= '0;
        bit_en <= '0;
      end
    end
  end

  // R10
  idle_no_cols_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |-> (col_en == '0));
  // R2
  single_col_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !blk_q) |-> ($countones(col_en) == 1));
  // R4
  unmasked_full_chk: assert property (@(posedge clk) disable iff (rst)
    ((is_wr || is_blk) && !masked && (&lane_en)) |=> (bit_en == '1));
  // R3
  blk_color_chk: assert property (@(posedge clk) disable iff (rst)
    is_blk |=> (wr_data == $past(color_q)));
endmodule

// File: rtl/blk_col_array.sv
module blk_col_array #(
  parameter int DW       = 16,
  parameter int COL_AW   = 9,
  parameter int BLK_COLS = 8
) (
  input  logic                       clk,
  input  logic                       wr_valid,
  input  logic [COL_AW-$clog2(BLK_COLS)-1:0] wr_blk,
  input  logic [BLK_COLS-1:0]        col_en,
  input  logic [DW-1:0]              bit_en,
  input  logic [DW-1:0]              wr_data,
  input  logic [COL_AW-1:0]          rd_col,
  output logic [DW-1:0]              rd_data
);
  localparam int SEL_W  = $clog2(BLK_COLS);
  localparam int BLK_AW = COL_AW - SEL_W;
  localparam int BLKS   = 1 << BLK_AW;

  logic [DW-1:0]    lane_q [BLK_COLS];
  logic [SEL_W-1:0] rd_sel_q;

  for (genvar c = 0; c < BLK_COLS; c++) begin : g_col
    logic [DW-1:0] mem [BLKS];
    always_ff @(posedge clk) begin
      if (wr_valid && col_en[c]) begin
        for (int b = 0; b < DW; b++) begin
          if (bit_en[b]) mem[wr_blk][b] <= wr_data[b];
        end
      end
      lane_q[c] <= mem[rd_col[COL_AW-1:SEL_W]];
    end
  end

  always_ff @(posedge clk) rd_sel_q <= rd_col[SEL_W-1:0];

  assign rd_data = lane_q[rd_sel_q];
endmodule

// File: rtl/vram_wr_path.sv
module vram_wr_path #(
  parameter int DW       = 16,
  parameter int COL_AW   = 9,
  parameter int BLK_COLS = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [2:0]                 op_code,
  input  logic                       masked,
  input  logic [DW-1:0]              mask_in,
  input  logic [COL_AW-1:0]          col_addr,
  input  logic [DW-1:0]              dq,
  input  logic                       be_lo,
  input  logic                       be_hi,
  input  logic [COL_AW-1:0]          rd_col,
  output logic                       wr_valid,
  output logic [COL_AW-$clog2(BLK_COLS)-1:0] wr_blk,
  output logic [BLK_COLS-1:0]        col_en,
  output logic [DW-1:0]              bit_en,
  output logic [DW-1:0]              wr_data,
  output logic [DW-1:0]              rd_data
);
  localparam int LANES = 2;

  logic [LANES-1:0] lane_en;
  logic [DW-1:0]    mask_q, color_q;
  logic             persist_q;

  assign lane_en = {be_hi, be_lo};

  wr_mask_regs #(.DW(DW), .LANES(LANES)) u_regs (
    .clk(clk), .rst(rst), .op_code(op_code), .dq(dq), .lane_en(lane_en),
    .mask_q(mask_q), .color_q(color_q), .persist_q(persist_q)
  );

  wr_enable_gen #(.DW(DW), .LANES(LANES), .COL_AW(COL_AW), .BLK_COLS(BLK_COLS)) u_gen (
    .clk(clk), .rst(rst), .op_code(op_code), .masked(masked), .mask_in(mask_in),
    .col_addr(col_addr), .dq(dq), .lane_en(lane_en), .mask_q(mask_q),
    .color_q(color_q), .persist_q(persist_q), .wr_valid(wr_valid),
    .wr_blk(wr_blk), .col_en(col_en), .bit_en(bit_en), .wr_data(wr_data)
  );

  blk_col_array #(.DW(DW), .COL_AW(COL_AW), .BLK_COLS(BLK_COLS)) u_arr (
    .clk(clk), .wr_valid(wr_valid), .wr_blk(wr_blk), .col_en(col_en),
    .bit_en(bit_en), .wr_data(wr_data), .rd_col(rd_col), .rd_data(rd_data)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (!wr_valid && col_en == '0 && bit_en == '0));
endmodule

// File: tb/vram_wr_path_tb.sv
module vram_wr_path_tb;
  import vram_wr_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_code = OP_NOP;
  logic        masked = 1'b0;
  logic [15:0] mask_in = '0;
  logic [8:0]  col_addr = '0;
  logic [15:0] dq = '0;
  logic        be_lo = 1'b1, be_hi = 1'b1;
  logic [8:0]  rd_col = '0;
  logic        wr_valid;
  logic [5:0]  wr_blk;
  logic [7:0]  col_en;
  logic [15:0] bit_en, wr_data, rd_data;

  int nchecks = 0, nfail = 0;
  bit done = 0;

  logic [15:0] ref_mem [512];
  logic [15:0] ref_mask = '0, ref_color = '0;
  logic        ref_persist = 1'b0;

  always #10 clk = ~clk;

  vram_wr_path u_dut (
    .clk(clk), .rst(rst), .op_code(op_code), .masked(masked), .mask_in(mask_in),
    .col_addr(col_addr), .dq(dq), .be_lo(be_lo), .be_hi(be_hi), .rd_col(rd_col),
    .wr_valid(wr_valid), .wr_blk(wr_blk), .col_en(col_en), .bit_en(bit_en),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] k, input logic m, input logic [15:0] mi,
                       input logic [8:0] a, input logic [15:0] d,
                       input logic lo, input logic hi, input string tag);
    logic [15:0] lanes, eb, ed;
    logic [7:0]  ec;
    op_code = k; masked = m; mask_in = mi; col_addr = a; dq = d; be_lo = lo; be_hi = hi;
    lanes = {{8{hi}}, {8{lo}}};
    eb = (!m ? 16'hFFFF : (ref_persist ? ref_mask : mi)) & lanes;
    if (k == OP_BLKWR) begin ec = d[7:0]; ed = ref_color; end
    else begin ec = 8'b1 << a[2:0]; ed = d; end
    @(posedge clk); @(negedge clk);
    if (k == OP_WRITE || k == OP_BLKWR) begin
      chk({tag, " wr_valid"}, 32'(wr_valid), 32'd1);
      chk({tag, " wr_blk"}, 32'(wr_blk), 32'(a[8:3]));
      chk({tag, " col_en"}, 32'(col_en), 32'(ec));
      chk({tag, " bit_en"}, 32'(bit_en), 32'(eb));
      chk({tag, " wr_data"}, 32'(wr_data), 32'(ed));
      for (int c = 0; c < 8; c++) begin
        if (ec[c]) begin
          ref_mem[{a[8:3], 3'(c)}] = (ref_mem[{a[8:3], 3'(c)}] & ~eb) | (ed & eb);
        end
      end
    end else begin
      chk("R10 wr_valid idle", 32'(wr_valid), 32'd0);
      chk("R10 col_en idle", 32'(col_en), 32'd0);
      if (k == OP_LDMASK) begin
        if (lo) ref_mask[7:0] = d[7:0];
        if (hi) ref_mask[15:8] = d[15:8];
        ref_persist = 1'b1;
      end else if (k == OP_LDCOLOR) begin
        if (lo) ref_color[7:0] = d[7:0];
        if (hi) ref_color[15:8] = d[15:8];
      end else if (k == OP_RFSH_CLR) begin
        ref_persist = 1'b0;
      end
    end
  endtask

  task automatic readback_all(input string tag);
    op_code = OP_NOP;
    @(posedge clk); @(posedge clk); @(negedge clk);
    for (int c = 0; c < 512; c++) begin
      rd_col = 9'(c);
      @(posedge clk); @(negedge clk);
      chk(tag, 32'(rd_data), 32'(ref_mem[c]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 512; c++) ref_mem[c] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 wr_valid", 32'(wr_valid), 32'd0);
    chk("R1 col_en", 32'(col_en), 32'd0);
    chk("R1 bit_en", 32'(bit_en), 32'd0);
    rst = 1'b0;
    // R1: color reset to zero, used to clear the whole array
    for (int b = 0; b < 64; b++)
      do_op(OP_BLKWR, 1'b0, 16'h0, 9'(b * 8 + (b % 8)), 16'h00FF, 1'b1, 1'b1, "R3");
    // R2 normal writes, R5 nonpersistent mask
    do_op(OP_WRITE, 1'b0, 16'h0, 9'd13, 16'hA5C3, 1'b1, 1'b1, "R2");
    do_op(OP_WRITE, 1'b1, 16'h0F0F, 9'd14, 16'hFFFF, 1'b1, 1'b1, "R5");
    // R8 byte strobes on a write and on loads
    do_op(OP_WRITE, 1'b0, 16'h0, 9'd15, 16'h1234, 1'b0, 1'b1, "R8");
    do_op(OP_LDCOLOR, 1'b0, 16'h0, 9'd0, 16'hBEEF, 1'b1, 1'b1, "R8");
    do_op(OP_LDCOLOR, 1'b0, 16'h0, 9'd0, 16'h7700, 1'b0, 1'b1, "R8");
    // R3 block write with sparse columns, low address bits nonzero
    do_op(OP_BLKWR, 1'b0, 16'h0, 9'd37, 16'h0055, 1'b1, 1'b1, "R3");
    do_op(OP_BLKWR, 1'b0, 16'h0, 9'd70, 16'h0081, 1'b1, 1'b0, "R8");
    // R6 persistent mask overrides mask_in
    do_op(OP_LDMASK, 1'b0, 16'h0, 9'd0, 16'hF00F, 1'b1, 1'b1, "R6");
    do_op(OP_WRITE, 1'b1, 16'h00FF, 9'd100, 16'hFFFF, 1'b1, 1'b1, "R6");
    do_op(OP_LDMASK, 1'b0, 16'h0, 9'd0, 16'hAAAA, 1'b0, 1'b1, "R8");
    do_op(OP_BLKWR, 1'b1, 16'hFFFF, 9'd200, 16'h00F0, 1'b1, 1'b1, "R6");
    // R4 unmasked write leaves stored mask intact
    do_op(OP_WRITE, 1'b0, 16'h0, 9'd101, 16'h5555, 1'b1, 1'b1, "R4");
    do_op(OP_WRITE, 1'b1, 16'h0000, 9'd102, 16'hFFFF, 1'b1, 1'b1, "R4");
    // R7 plain refresh keeps persistence, clear refresh ends it
    do_op(OP_RFSH, 1'b0, 16'h0, 9'd0, 16'h0, 1'b1, 1'b1, "R7");
    do_op(OP_WRITE, 1'b1, 16'h0001, 9'd103, 16'hFFFF, 1'b1, 1'b1, "R7");
    do_op(OP_RFSH_CLR, 1'b0, 16'h0, 9'd0, 16'h0, 1'b1, 1'b1, "R7");
    do_op(OP_WRITE, 1'b1, 16'h0001, 9'd104, 16'hFFFF, 1'b1, 1'b1, "R7");
    do_op(3'd7, 1'b0, 16'h0, 9'd0, 16'h0, 1'b1, 1'b1, "R10");
    readback_all("R9 directed readback");
    // R9 random mix
    for (int i = 0; i < 1500; i++) begin
      int r;
      logic [2:0] k;
      r = int'($urandom % 10);
      if (r < 4) k = OP_WRITE;
      else if (r < 7) k = OP_BLKWR;
      else if (r == 7) k = OP_LDMASK;
      else if (r == 8) k = OP_LDCOLOR;
      else k = ($urandom % 2 == 0) ? OP_RFSH : OP_RFSH_CLR;
      do_op(k, 1'($urandom), 16'($urandom), 9'($urandom), 16'($urandom),
            1'($urandom), 1'($urandom), "R9");
    end
    readback_all("R9 random readback");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule